// File: doc/BRIEF.md
# Packed Multimedia Integer Unit

This block is a 64-bit execution unit for a small family of packed-integer operate instructions. Each cycle it may accept one 32-bit instruction word together with two 64-bit register values already read by the surrounding pipeline. It decodes the instruction and computes the result combinationally. One clock later it presents a registered 64-bit result, the destination register index and an illegal-instruction flag, all qualified by a valid strobe.

The supported work covers several kinds of operation. There is lane-wise minimum and maximum over eight byte lanes or four 16-bit lanes, each in signed and unsigned forms. There is sign extension from bit 7 or bit 15. There are gathers that pack wide lanes down to bytes and scatters that unpack bytes up to wide lanes. Finally there is a pixel-error sum of absolute byte differences. Signed lanes reuse the unsigned comparators: the top bit of every lane of both operands is inverted before the compare. Register file access, trap handling and writeback belong to the caller, which reads the `out_illegal` flag to raise a trap.

Top module: `pmx_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state is `out_valid`=0, `out_result`=0, `out_dest`=0 and `out_illegal`=0.
- R2: `out_valid` is `in_valid` delayed by exactly one clock. When it is high, `out_dest` equals bits 4:0 of the instruction accepted one clock earlier.
- R3: The second operand is `opnd_b` when instruction bit 12 is 0. When bit 12 is 1, the second operand is the 8-bit literal in bits 20:13, zero-extended to 64 bits.
- R4: Byte-lane min/max works on eight independent 8-bit lanes, with `opnd_a` as the first operand. The function codes (bits 10:5) are: 0x3A unsigned min, 0x3C unsigned max, 0x38 signed min, 0x3E signed max.
- R5: Word-lane min/max works on four independent 16-bit lanes. The function codes are: 0x3B unsigned min, 0x3D unsigned max, 0x39 signed min, 0x3F signed max.
- R6: Function 0x00 sign-extends bit 7 of the second operand through bits 63:8. Function 0x01 sign-extends bit 15 through bits 63:16. `opnd_a` has no effect on either result.
- R7: Function 0x36 places second-operand bytes 6, 4, 2 and 0 in result bytes 3, 2, 1 and 0. Function 0x37 places bytes 4 and 0 in result bytes 1 and 0. All other result bytes are zero.
- R8: Function 0x34 places second-operand bytes 0, 1, 2 and 3 in result bytes 0, 2, 4 and 6. Function 0x35 places bytes 0 and 1 in result bytes 0 and 4. All other result bytes are zero.
- R9: Function 0x31 returns the sum of the eight unsigned absolute byte differences between `opnd_a` and the second operand in bits 10:0, with bits 63:11 zero.
- R10: An instruction whose bits 31:26 differ from 0x1C, or whose function code is not listed in R4 to R9, gives `out_illegal`=1 and `out_result`=0.
- R11: While `in_valid` is low, `out_result`, `out_dest` and `out_illegal` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction and operands are presented this cycle |
| insn | input | 32 | Instruction word |
| opnd_a | input | 64 | Value of source register A |
| opnd_b | input | 64 | Value of source register B (unused when bit 12 selects the literal) |
| out_valid | output | 1 | Registered result is valid |
| out_result | output | 64 | Registered result |
| out_dest | output | 5 | Destination register index |
| out_illegal | output | 1 | Instruction not handled by this unit |

## Verification
The assertions assume that the instruction word and operands are at known values whenever `in_valid` is high. They make no assumption about the inputs while `in_valid` is low, so the bench drives unrelated random values in idle cycles to exercise the hold rule. The checks on sign-extension shape, pack zero bytes and the pixel-error width rely on the opcode field holding 0x1C, so the stimulus draws most function codes from the legal set. It sends the occasional unknown code or foreign opcode so that the illegal path is also covered.

// File: rtl/pmx_pkg.sv
// pmx_pkg: shared types and constants for the packed multimedia unit.
// Assumes a 64-bit datapath made of 8-bit bytes.
package pmx_pkg;
    localparam int DATA_W   = 64;
    localparam int BYTE_W   = 8;
    localparam int NBYTES   = DATA_W / BYTE_W;
    localparam int SAD_W    = $clog2(NBYTES * 255 + 1);
    localparam int INSN_W   = 32;
    localparam int REG_IDX_W = 5;

    localparam logic [5:0] MAJOR_OPC = 6'h1C;

    // function codes
    localparam logic [5:0] FN_SEXT_B  = 6'h00;
    localparam logic [5:0] FN_SEXT_W  = 6'h01;
    localparam logic [5:0] FN_PIXERR  = 6'h31;
    localparam logic [5:0] FN_SPRD_W  = 6'h34;
    localparam logic [5:0] FN_SPRD_L  = 6'h35;
    localparam logic [5:0] FN_GATH_W  = 6'h36;
    localparam logic [5:0] FN_GATH_L  = 6'h37;
    localparam logic [5:0] FN_SMIN_B  = 6'h38;
    localparam logic [5:0] FN_SMIN_W  = 6'h39;
    localparam logic [5:0] FN_UMIN_B  = 6'h3A;
    localparam logic [5:0] FN_UMIN_W  = 6'h3B;
    localparam logic [5:0] FN_UMAX_B  = 6'h3C;
    localparam logic [5:0] FN_UMAX_W  = 6'h3D;
    localparam logic [5:0] FN_SMAX_B  = 6'h3E;
    localparam logic [5:0] FN_SMAX_W  = 6'h3F;

    typedef enum logic [3:0] {
        K_NONE,
        K_SEXT_B,
        K_SEXT_W,
        K_PIXERR,
        K_SPREAD,
        K_GATHER,
        K_MINMAX
    } pmx_kind_e;

    typedef struct packed {
        pmx_kind_e  kind;
        logic [2:0] stride;     // byte stride for gather/spread (2 or 4)
        logic       word_lanes; // min/max on 16-bit lanes
        logic       sgn;        // signed lane compare
        logic       take_max;   // maximum rather than minimum
        logic       use_lit;    // second operand from the literal field
        logic       illegal;
    } pmx_ctl_t;
endpackage

// File: rtl/pmx_decode.sv
// pmx_decode: turns an instruction word into datapath controls.
// Assumes the caller qualifies the word with its own valid strobe;
// any foreign major opcode or unlisted function code is flagged illegal.
module pmx_decode
    import pmx_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output pmx_ctl_t          ctl
);
    logic [5:0] major;
    logic [5:0] fn;

    assign major = insn[31:26];
    assign fn    = insn[10:5];

    // Map the function field onto an operation kind and its modifiers.
    always_comb begin
        ctl            = '0;
        ctl.kind       = K_NONE;
        ctl.use_lit    = insn[12];
        ctl.stride     = 3'd2;
        unique case (fn)
            FN_SEXT_B: ctl.kind = K_SEXT_B;
            FN_SEXT_W: ctl.kind = K_SEXT_W;
            FN_PIXERR: ctl.kind = K_PIXERR;
            FN_SPRD_W: ctl.kind = K_SPREAD;
            FN_SPRD_L: begin ctl.kind = K_SPREAD; ctl.stride = 3'd4; end
            FN_GATH_W: ctl.kind = K_GATHER;
            FN_GATH_L: begin ctl.kind = K_GATHER; ctl.stride = 3'd4; end
            FN_SMIN_B: begin ctl.kind = K_MINMAX; ctl.sgn = 1'b1; end
            FN_SMIN_W: begin ctl.kind = K_MINMAX; ctl.sgn = 1'b1; ctl.word_lanes = 1'b1; end
            FN_UMIN_B: ctl.kind = K_MINMAX;
            FN_UMIN_W: begin ctl.kind = K_MINMAX; ctl.word_lanes = 1'b1; end
            FN_UMAX_B: begin ctl.kind = K_MINMAX; ctl.take_max = 1'b1; end
            FN_UMAX_W: begin ctl.kind = K_MINMAX; ctl.take_max = 1'b1; ctl.word_lanes = 1'b1; end
            FN_SMAX_B: begin ctl.kind = K_MINMAX; ctl.take_max = 1'b1; ctl.sgn = 1'b1; end
            FN_SMAX_W: begin
                ctl.kind = K_MINMAX; ctl.take_max = 1'b1; ctl.sgn = 1'b1; ctl.word_lanes = 1'b1;
            end
            default:   ctl.kind = K_NONE;
        endcase
        if (major != MAJOR_OPC) begin
            ctl.kind = K_NONE;
        end
        ctl.illegal = (ctl.kind == K_NONE);
    end
endmodule

// File: rtl/pmx_minmax.sv
// pmx_minmax: lane-wise minimum or maximum of two vectors.
// Signed lanes are compared by inverting each lane's top bit on both
// operands and using the unsigned comparator; the result keeps the
// original lane values. Assumes DATA_W is a multiple of LANE_W.
module pmx_minmax #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sgn,
    input  logic              take_max,
    output logic [DATA_W-1:0] y
);
    localparam int NLANES = DATA_W / LANE_W;

    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        logic [LANE_W-1:0] la, lb, fa, fb;
        logic              a_ge_b;

        assign la = a[i*LANE_W +: LANE_W];
        assign lb = b[i*LANE_W +: LANE_W];
        // Bias signed lanes into unsigned order.
        assign fa = {la[LANE_W-1] ^ sgn, la[LANE_W-2:0]};
        assign fb = {lb[LANE_W-1] ^ sgn, lb[LANE_W-2:0]};
        assign a_ge_b = (fa >= fb);
        // Pick the lane value the operation asks for.
        assign y[i*LANE_W +: LANE_W] = (a_ge_b == take_max) ? la : lb;
    end
endmodule

// File: rtl/pmx_shuffle.sv
// pmx_shuffle: byte gathers, byte spreads and sign extensions of the
// second operand. Gather takes every STRIDE-th source byte into the low
// result bytes; spread does the inverse. Assumes stride is 2 or 4.
module pmx_shuffle
    import pmx_pkg::*;
(
    input  pmx_kind_e         kind,
    input  logic [2:0]        stride,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    logic [DATA_W-1:0] gath2, gath4, sprd2, sprd4;

    // Build the four byte rearrangements with fixed strides.
    always_comb begin
        gath2 = '0;
        gath4 = '0;
        sprd2 = '0;
        sprd4 = '0;
        for (int i = 0; i < NBYTES / 2; i++) begin
            gath2[i*BYTE_W +: BYTE_W]     = b[2*i*BYTE_W +: BYTE_W];
            sprd2[2*i*BYTE_W +: BYTE_W]   = b[i*BYTE_W +: BYTE_W];
        end
        for (int i = 0; i < NBYTES / 4; i++) begin
            gath4[i*BYTE_W +: BYTE_W]     = b[4*i*BYTE_W +: BYTE_W];
            sprd4[4*i*BYTE_W +: BYTE_W]   = b[i*BYTE_W +: BYTE_W];
        end
    end

    // Choose the rearrangement or sign extension for this kind.
    always_comb begin
        unique case (kind)
            K_SEXT_B: y = {{(DATA_W-8){b[7]}}, b[7:0]};
            K_SEXT_W: y = {{(DATA_W-16){b[15]}}, b[15:0]};
            K_GATHER: y = (stride == 3'd4) ? gath4 : gath2;
            K_SPREAD: y = (stride == 3'd4) ? sprd4 : sprd2;
            default:  y = '0;
        endcase
    end
endmodule

// File: rtl/pmx_sad.sv
// pmx_sad: sum of absolute differences over all byte lanes.
// Assumes unsigned bytes; the sum fits in SAD_W bits.
module pmx_sad
    import pmx_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [SAD_W-1:0]  sum
);
    logic [NBYTES-1:0][BYTE_W-1:0] diff;

    for (genvar i = 0; i < NBYTES; i++) begin : g_diff
        logic [BYTE_W-1:0] xa, xb;
        assign xa = a[i*BYTE_W +: BYTE_W];
        assign xb = b[i*BYTE_W +: BYTE_W];
        // Larger minus smaller gives the absolute difference.
        assign diff[i] = (xa >= xb) ? (xa - xb) : (xb - xa);
    end

    // Accumulate the lane differences.
    always_comb begin
        sum = '0;
        for (int i = 0; i < NBYTES; i++) begin
            sum = sum + SAD_W'(diff[i]);
        end
    end
endmodule

// File: rtl/pmx_unit.sv
// pmx_unit: packed multimedia integer execution unit. Decodes one
// instruction per cycle, computes the result combinationally and registers
// it with the destination index and an illegal flag one clock later.
// Assumes operands are already read from the register file by the caller.
module pmx_unit
    import pmx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [INSN_W-1:0]    insn,
    input  logic [DATA_W-1:0]    opnd_a,
    input  logic [DATA_W-1:0]    opnd_b,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    out_result,
    output logic [REG_IDX_W-1:0] out_dest,
    output logic                 out_illegal
);
    localparam int NVARIANT = 2;   // byte lanes and word lanes

    pmx_ctl_t          ctl;
    logic [DATA_W-1:0] src2;
    logic [DATA_W-1:0] mm_y [NVARIANT];
    logic [DATA_W-1:0] shuf_y;
    logic [SAD_W-1:0]  sad_sum;
    logic [DATA_W-1:0] res_next;
    logic              unused_fields;

    assign unused_fields = ^{insn[25:21], insn[11]};

    pmx_decode u_decode (
        .insn (insn),
        .ctl  (ctl)
    );

    // Second operand: register value or zero-extended literal.
    assign src2 = ctl.use_lit ? {{(DATA_W-8){1'b0}}, insn[20:13]} : opnd_b;

    for (genvar g = 0; g < NVARIANT; g++) begin : g_mm
        pmx_minmax #(
            .DATA_W (DATA_W),
            .LANE_W (BYTE_W << g)
        ) u_minmax (
            .a        (opnd_a),
            .b        (src2),
            .sgn      (ctl.sgn),
            .take_max (ctl.take_max),
            .y        (mm_y[g])
        );
    end

    pmx_shuffle u_shuffle (
        .kind   (ctl.kind),
        .stride (ctl.stride),
        .b      (src2),
        .y      (shuf_y)
    );

    pmx_sad u_sad (
        .a   (opnd_a),
        .b   (src2),
        .sum (sad_sum)
    );

    // Select the result of the decoded operation.
    always_comb begin
        unique case (ctl.kind)
            K_MINMAX: res_next = ctl.word_lanes ? mm_y[1] : mm_y[0];
            K_SEXT_B, K_SEXT_W, K_GATHER, K_SPREAD: res_next = shuf_y;
            K_PIXERR: res_next = {{(DATA_W-SAD_W){1'b0}}, sad_sum};
            default:  res_next = '0;
        endcase
    end

    // Output register: strobe every cycle, payload only on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_dest    <= '0;
            out_illegal <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result  <= res_next;
                out_dest    <= insn[REG_IDX_W-1:0];
                out_illegal <= ctl.illegal;
            end
        end
    end
endmodule

// File: rtl/pmx_unit_chk.sv
// pmx_unit_chk: port-level properties of pmx_unit, bound to every instance.
module pmx_unit_chk
    import pmx_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [INSN_W-1:0]    insn,
    input logic                 out_valid,
    input logic [DATA_W-1:0]    out_result,
    input logic [REG_IDX_W-1:0] out_dest,
    input logic                 out_illegal
);
    logic is_ours;
    assign is_ours = in_valid && (insn[31:26] == MAJOR_OPC);

    p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_dest_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_dest == $past(insn[4:0]));
    p_illegal_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> out_result == '0);
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result) && $stable(out_dest) && $stable(out_illegal));
    p_sext_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ours && insn[10:5] == FN_SEXT_B) |=>
            (out_result[63:7] == '0 || out_result[63:7] == '1));
    p_gather_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ours && (insn[10:5] == FN_GATH_W || insn[10:5] == FN_GATH_L)) |=>
            out_result[63:32] == '0 && !out_illegal);
    p_pixerr_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ours && insn[10:5] == FN_PIXERR) |=> out_result[63:11] == '0);
endmodule

bind pmx_unit pmx_unit_chk u_pmx_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .insn        (insn),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_dest    (out_dest),
    .out_illegal (out_illegal)
);

// File: tb/pmx_unit_bench.sv
`timescale 1ns/1ps
module pmx_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] insn = '0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic        out_valid;
    logic [63:0] out_result;
    logic [4:0]  out_dest;
    logic        out_illegal;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    pmx_unit u_pmx_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid),
        .out_result(out_result), .out_dest(out_dest), .out_illegal(out_illegal)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [5:0] opc, input logic [5:0] fn,
                                       input logic lit, input logic [7:0] litv,
                                       input logic [4:0] rd);
        logic [31:0] w;
        w = $urandom;
        w[31:26] = opc;
        w[10:5]  = fn;
        w[12]    = lit;
        w[4:0]   = rd;
        if (lit) w[20:13] = litv;
        return w;
    endfunction

    // Reference model written from the requirements.
    function automatic logic [63:0] model(input logic [31:0] w, input logic [63:0] a,
                                          input logic [63:0] rb, output logic ill);
        logic [63:0] s, r;
        logic [5:0]  fn;
        int          acc;
        s  = w[12] ? {56'd0, w[20:13]} : rb;
        fn = w[10:5];
        r  = '0;
        ill = 1'b0;
        if (w[31:26] != 6'h1C) begin
            ill = 1'b1;
            return '0;
        end
        case (fn)
            6'h00: r = 64'($signed(s[7:0]));
            6'h01: r = 64'($signed(s[15:0]));
            6'h31: begin
                acc = 0;
                for (int i = 0; i < 8; i++) begin
                    int x, y;
                    x = int'(a[i*8 +: 8]);
                    y = int'(s[i*8 +: 8]);
                    acc += (x > y) ? x - y : y - x;
                end
                r = 64'(acc);
            end
            6'h34: for (int i = 0; i < 4; i++) r[i*16 +: 8] = s[i*8 +: 8];
            6'h35: for (int i = 0; i < 2; i++) r[i*32 +: 8] = s[i*8 +: 8];
            6'h36: for (int i = 0; i < 4; i++) r[i*8 +: 8] = s[i*16 +: 8];
            6'h37: for (int i = 0; i < 2; i++) r[i*8 +: 8] = s[i*32 +: 8];
            6'h38, 6'h3A, 6'h3C, 6'h3E:
                for (int i = 0; i < 8; i++) begin
                    int x, y;
                    logic pick_a;
                    if (fn == 6'h38 || fn == 6'h3E) begin
                        x = int'($signed(a[i*8 +: 8])); y = int'($signed(s[i*8 +: 8]));
                    end else begin
                        x = int'(a[i*8 +: 8]); y = int'(s[i*8 +: 8]);
                    end
                    pick_a = (fn == 6'h3C || fn == 6'h3E) ? (x >= y) : (x <= y);
                    r[i*8 +: 8] = pick_a ? a[i*8 +: 8] : s[i*8 +: 8];
                end
            6'h39, 6'h3B, 6'h3D, 6'h3F:
                for (int i = 0; i < 4; i++) begin
                    int x, y;
                    logic pick_a;
                    if (fn == 6'h39 || fn == 6'h3F) begin
                        x = int'($signed(a[i*16 +: 16])); y = int'($signed(s[i*16 +: 16]));
                    end else begin
                        x = int'(a[i*16 +: 16]); y = int'(s[i*16 +: 16]);
                    end
                    pick_a = (fn == 6'h3D || fn == 6'h3F) ? (x >= y) : (x <= y);
                    r[i*16 +: 16] = pick_a ? a[i*16 +: 16] : s[i*16 +: 16];
                end
            default: ill = 1'b1;
        endcase
        return r;
    endfunction

    // Apply one instruction and compare the registered outputs one clock later.
    task automatic run(input string req, input logic [31:0] w, input logic [63:0] a,
                       input logic [63:0] b);
        logic [63:0] exp;
        logic        ill;
        exp = model(w, a, b, ill);
        @(negedge clk);
        insn = w; opnd_a = a; opnd_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " R2 valid"}, 64'(out_valid), 64'd1);
        chk({req, " R2 dest"}, 64'(out_dest), 64'(w[4:0]));
        chk({req, " R10 illegal"}, 64'(out_illegal), 64'(ill));
        chk(req, out_result, exp);
    endtask

    // Idle cycle with junk inputs: outputs must hold (R11).
    task automatic idle_hold();
        logic [63:0] r0;
        logic [4:0]  d0;
        logic        i0;
        r0 = out_result; d0 = out_dest; i0 = out_illegal;
        insn = $urandom; opnd_a = {$urandom, $urandom}; opnd_b = {$urandom, $urandom};
        @(negedge clk);
        chk("R11 valid low", 64'(out_valid), 64'd0);
        chk("R11 result held", out_result, r0);
        chk("R11 dest held", 64'(out_dest), 64'(d0));
        chk("R11 illegal held", 64'(out_illegal), 64'(i0));
    endtask

    initial begin
        #(4.0 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [5:0] legal [14];
        legal = '{6'h00, 6'h01, 6'h31, 6'h34, 6'h35, 6'h36, 6'h37,
                  6'h38, 6'h39, 6'h3A, 6'h3B, 6'h3C, 6'h3D, 6'h3E};
        void'($urandom(32'h5eed_1234));
        insn = 32'hFFFF_FFFF; opnd_a = '1; opnd_b = '1; in_valid = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state even with in_valid high
        chk("R1 valid", 64'(out_valid), 64'd0);
        chk("R1 result", out_result, 64'd0);
        chk("R1 dest", 64'(out_dest), 64'd0);
        chk("R1 illegal", 64'(out_illegal), 64'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corner cases
        run("R4 signed byte min 80/7F", mk(6'h1C, 6'h38, 0, 0, 5'd3),
            64'h8000_7F01_FF80_0102, 64'h7F80_807F_01FF_0201);
        run("R4 unsigned byte max", mk(6'h1C, 6'h3C, 0, 0, 5'd4),
            64'h8000_7F01_FF80_0102, 64'h7F80_807F_01FF_0201);
        run("R4 signed byte max", mk(6'h1C, 6'h3E, 0, 0, 5'd5),
            64'h8000_7F01_FF80_0102, 64'h7F80_807F_01FF_0201);
        run("R4 unsigned byte min", mk(6'h1C, 6'h3A, 0, 0, 5'd6),
            64'h8000_7F01_FF80_0102, 64'h7F80_807F_01FF_0201);
        run("R5 signed word min 8000/7FFF", mk(6'h1C, 6'h39, 0, 0, 5'd7),
            64'h8000_7FFF_FFFF_0001, 64'h7FFF_8000_0000_FFFF);
        run("R5 unsigned word max", mk(6'h1C, 6'h3D, 0, 0, 5'd8),
            64'h8000_7FFF_FFFF_0001, 64'h7FFF_8000_0000_FFFF);
        run("R5 signed word max", mk(6'h1C, 6'h3F, 0, 0, 5'd9),
            64'h8000_7FFF_FFFF_0001, 64'h7FFF_8000_0000_FFFF);
        run("R5 unsigned word min", mk(6'h1C, 6'h3B, 0, 0, 5'd10),
            64'h8000_7FFF_FFFF_0001, 64'h7FFF_8000_0000_FFFF);
        run("R3 literal FF zero-extended", mk(6'h1C, 6'h3C, 1, 8'hFF, 5'd11),
            64'h0000_0000_0000_0010, 64'hDEAD_BEEF_0000_0000);
        run("R6 sext byte negative, A ignored", mk(6'h1C, 6'h00, 0, 0, 5'd12),
            64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DE80);
        run("R6 sext word positive, A ignored", mk(6'h1C, 6'h01, 0, 0, 5'd13),
            64'hAAAA_AAAA_AAAA_AAAA, 64'hFFFF_FFFF_FFFF_7FFF);
        run("R7 gather words", mk(6'h1C, 6'h36, 0, 0, 5'd14),
            64'h0, 64'h8877_6655_4433_2211);
        run("R7 gather longwords", mk(6'h1C, 6'h37, 0, 0, 5'd15),
            64'h0, 64'h8877_6655_4433_2211);
        run("R8 spread to words", mk(6'h1C, 6'h34, 0, 0, 5'd16),
            64'h0, 64'h8877_6655_4433_2211);
        run("R8 spread to longwords", mk(6'h1C, 6'h35, 0, 0, 5'd17),
            64'h0, 64'h8877_6655_4433_2211);
        run("R9 pixel error max 2040", mk(6'h1C, 6'h31, 0, 0, 5'd18),
            64'h0, 64'hFFFF_FFFF_FFFF_FFFF);
        run("R9 pixel error literal", mk(6'h1C, 6'h31, 1, 8'h05, 5'd19),
            64'h0102_0304_0506_0708, 64'h0);
        run("R10 unknown function 02", mk(6'h1C, 6'h02, 0, 0, 5'd20),
            64'h1, 64'h2);
        run("R10 foreign opcode", mk(6'h10, 6'h3C, 0, 0, 5'd21),
            64'h1, 64'h2);
        idle_hold();

        // Constrained random mix
        for (int n = 0; n < 600; n++) begin
            logic [5:0]  opc, fn;
            logic [31:0] w;
            opc = ($urandom_range(0, 15) == 0) ? 6'($urandom) : 6'h1C;
            fn  = ($urandom_range(0, 7) == 0) ? 6'($urandom) : legal[$urandom_range(0, 13)];
            if ($urandom_range(0, 13) == 0) fn = 6'h3F;
            w = mk(opc, fn, 1'($urandom), 8'($urandom), 5'($urandom));
            run("R3-R10 random", w, {$urandom, $urandom}, {$urandom, $urandom});
            if ((n % 8) == 0) idle_hold();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule